// File: doc/BRIEF.md
# Period-Based Audio Ring Playback DMA

This block is a playback DMA channel for audio. Software describes a ring buffer in memory with a 64-bit base address, a period length in bytes and a period count. Once the channel is enabled, it fetches the ring in 64-byte bursts over a request/acknowledge read port. It sends each fetched word out on an AXI4-Stream master, in address order, and wraps to the start of the ring after the last period.

At every period boundary the block sets a completion flag. Software clears the flag by writing a 1 to it, and the flag drives an interrupt output when its enable bit is set. Software can read the current byte position within the ring. A self-clearing soft reset returns the channel to its start position and drops any burst in flight. The channel-count and sample-width fields of the control register are stored for software and read back. A read-only configuration word reports what the channel was built with.

All registers are 32 bits wide. Writes take effect on the clock edge at which `reg_we` is high, and reads are combinational from `reg_addr`.

Top module: `audio_ring_dma`

## Requirements
- R1: After reset, the following registers read 0: control (0x10), status (0x14) and position (0x28). The `irq`, `mem_req` and `m_axis_tvalid` outputs are low. The configuration word at 0x04 reads bit 15 = 1 (channel present), bits 14:13 = transfer mode, bit 12 = 0 (interleaved) and bits 11:8 = maximum channel count, with all other bits 0.
- R2: The control register at 0x10 holds these fields, and each one reads back as written: run enable in bit 0, completion interrupt enable in bit 13, timeout interrupt enable in bit 14, sample width code in bits 18:16 and active channel count in bits 22:19.
- R3: The period register at 0x1C holds the period count in bits 19:16 and the period length in bytes in bits 15:0. The buffer base low word is at 0x20 and the high word is at 0x24. All of these read back as written.
- R4: While run is enabled, the block fetches bursts of 64 bytes from base + position. Every stream beat carries the memory word at base + position, and positions advance by one word per beat.
- R5: The position register advances by 64 per completed burst and is always a multiple of 64. When it reaches period length × period count, it returns to 0.
- R6: `m_axis_tlast` is high on the last beat of each period and low on every other beat.
- R7: The completion flag in status bit 31 is set when a burst ends a period. Writing a 1 to bit 31 clears the flag, and writing a 0 leaves it unchanged.
- R8: `irq` is high exactly when the completion flag and control bit 13 are both set.
- R9: After run is cleared, the burst in progress still completes, so the number of beats streamed is a multiple of 8 (one 64-byte burst at 64-bit data). No new request starts. The position then equals the bytes streamed modulo the ring size.
- R10: Writing control bit 1 starts a soft reset. Bit 1 reads 1 for 4 cycles and then clears itself. The soft reset clears run enable, the position, the completion flag, the partly fetched burst and the pending output beat. It leaves the other control fields unchanged.
- R11: While `m_axis_tready` is low, `m_axis_tvalid` and `m_axis_tdata` hold steady. No beat is lost or repeated under stalls on either the stream or the memory side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Read request, high while the block can take a beat of the current burst |
| mem_addr | output | ADDR_W | Byte address of the current burst |
| mem_ack | input | 1 | Memory delivers one beat this cycle (allowed only while mem_req is high) |
| mem_rdata | input | DATA_W | Beat data |
| m_axis_tvalid | output | 1 | Stream beat valid |
| m_axis_tready | input | 1 | Stream sink ready |
| m_axis_tdata | output | DATA_W | Stream beat data |
| m_axis_tlast | output | 1 | Last beat of a period |
| irq | output | 1 | Period completion interrupt |

## Verification
The stream is run three ways: with both the memory and the sink always ready, with pseudo-random stalls on both sides, and after a soft reset that is followed by a different ring geometry. The stall-free run shows that data order, the wrap point and the per-period last marker are right at full rate. The stalled run separates a correct hold-and-no-loss handshake from one that drops or repeats beats, and it shows that the position register still settles on a burst boundary after run is cleared. The reset in the middle of a burst, followed by a 2 × 256-byte ring, shows that the position, the flag and any half-fetched burst are really discarded, and that streaming resumes at the base address.

// File: rtl/ard_pkg.sv
// Shared register map constants and types of the audio ring playback DMA.
package ard_pkg;
    localparam logic [7:0] A_CORE = 8'h04;
    localparam logic [7:0] A_CTRL = 8'h10;
    localparam logic [7:0] A_STAT = 8'h14;
    localparam logic [7:0] A_PCFG = 8'h1C;
    localparam logic [7:0] A_BLO  = 8'h20;
    localparam logic [7:0] A_BHI  = 8'h24;
    localparam logic [7:0] A_POS  = 8'h28;

    localparam int BURST_BYTES = 64;

    typedef struct packed {
        logic       run;
        logic       done_ie;
        logic       tout_ie;
        logic [2:0] width;
        logic [3:0] chans;
    } ctrl_t;
endpackage

// File: rtl/audio_ring_dma_regs.sv
// Register file: control, status flag with write-1-to-clear, ring geometry,
// base address, self-timed soft reset and the interrupt output.
// Assumes single-cycle writes and side-effect-free combinational reads.
module audio_ring_dma_regs
    import ard_pkg::*;
#(
    parameter int         OFS_W      = 20,
    parameter int         RST_CYCLES = 4,
    parameter logic [3:0] MAX_CH     = 4'd8,
    parameter logic [1:0] XFER_MODE  = 2'd2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             period_done,
    input  logic [OFS_W-1:0] pos,
    output ctrl_t            ctrl,
    output logic             srst,
    output logic [63:0]      base,
    output logic [15:0]      pbytes,
    output logic [3:0]       pcount,
    output logic             flag,
    output logic             irq
);
    localparam int RC_W = $clog2(RST_CYCLES + 1);
    localparam logic [31:0] CORE_WORD = {16'h0, 1'b1, XFER_MODE, 1'b0, MAX_CH, 8'h00};

    logic [RC_W-1:0] rst_cnt;
    logic            wr_ctrl, wr_stat;

    assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
    assign wr_stat = reg_we && (reg_addr == A_STAT);

    // Control fields and the soft reset countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl    <= '0;
            srst    <= 1'b0;
            rst_cnt <= '0;
        end else if (wr_ctrl) begin
            ctrl.run     <= reg_wdata[0] && !reg_wdata[1];
            ctrl.done_ie <= reg_wdata[13];
            ctrl.tout_ie <= reg_wdata[14];
            ctrl.width   <= reg_wdata[18:16];
            ctrl.chans   <= reg_wdata[22:19];
            if (reg_wdata[1]) begin
                srst    <= 1'b1;
                rst_cnt <= RC_W'(RST_CYCLES);
            end
        end else if (srst) begin
            rst_cnt <= rst_cnt - 1'b1;
            if (rst_cnt == RC_W'(1)) srst <= 1'b0;
        end
    end

    // Ring geometry and base address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base   <= '0;
            pbytes <= '0;
            pcount <= '0;
        end else if (reg_we) begin
            if (reg_addr == A_PCFG) begin
                pbytes <= reg_wdata[15:0];
                pcount <= reg_wdata[19:16];
            end
            if (reg_addr == A_BLO) base[31:0]  <= reg_wdata;
            if (reg_addr == A_BHI) base[63:32] <= reg_wdata;
        end
    end

    // Completion flag: set by a period end, cleared by write-1 or soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || srst)                 flag <= 1'b0;
        else if (period_done)               flag <= 1'b1;
        else if (wr_stat && reg_wdata[31])  flag <= 1'b0;
    end

    assign irq = flag && ctrl.done_ie;

    // Read multiplexer.
    always_comb begin
        case (reg_addr)
            A_CORE:  reg_rdata = CORE_WORD;
            A_CTRL:  reg_rdata = {9'b0, ctrl.chans, ctrl.width, 1'b0, ctrl.tout_ie,
                                  ctrl.done_ie, 11'b0, srst, ctrl.run};
            A_STAT:  reg_rdata = {flag, 31'b0};
            A_PCFG:  reg_rdata = {12'b0, pcount, pbytes};
            A_BLO:   reg_rdata = base[31:0];
            A_BHI:   reg_rdata = base[63:32];
            A_POS:   reg_rdata = 32'(pos);
            default: reg_rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/audio_ring_dma_pos.sv
// Position tracker: byte offset in the ring, offset within the period and
// period index. Advances by one burst on burst_done and wraps at the ring end.
// Assumes the period length is a multiple of 64 and the count is at least 1.
module audio_ring_dma_pos
    import ard_pkg::*;
#(
    parameter int OFS_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             burst_done,
    input  logic [15:0]      pbytes,
    input  logic [3:0]       pcount,
    output logic [OFS_W-1:0] pos,
    output logic             period_last,
    output logic             period_done
);
    logic [15:0] in_period;
    logic [3:0]  pidx;
    logic        ring_last;

    assign period_last = ({1'b0, in_period} + 17'(BURST_BYTES)) >= {1'b0, pbytes};
    assign ring_last   = period_last && ((pidx + 4'd1) >= pcount);
    assign period_done = burst_done && period_last;

    // Advance the counters after each burst and wrap at the ring end.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            pos       <= '0;
            in_period <= '0;
            pidx      <= '0;
        end else if (burst_done) begin
            if (period_last) begin
                in_period <= '0;
                pidx      <= ring_last ? 4'd0 : pidx + 4'd1;
                pos       <= ring_last ? '0 : pos + OFS_W'(BURST_BYTES);
            end else begin
                in_period <= in_period + 16'(BURST_BYTES);
                pos       <= pos + OFS_W'(BURST_BYTES);
            end
        end
    end
endmodule

// File: rtl/audio_ring_dma_fetch.sv
// Burst fetcher: issues 64-byte read bursts while run is set, accepts beats
// only while its one-beat output register can take them, and marks the last
// beat of a period. Assumes memory acks only while mem_req is high.
module audio_ring_dma_fetch
    import ard_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64,
    parameter int OFS_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              run,
    input  logic [63:0]       base,
    input  logic [OFS_W-1:0]  pos,
    input  logic              period_last,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tlast,
    output logic              burst_done
);
    localparam int BEATS = BURST_BYTES / (DATA_W / 8);
    localparam int BC_W  = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic            busy;
    logic [BC_W-1:0] beat;
    logic            take, last_beat;

    assign mem_addr   = ADDR_W'(base) + ADDR_W'(pos);
    assign mem_req    = busy && !srst && (!m_tvalid || m_tready);
    assign take       = mem_req && mem_ack;
    assign last_beat  = (beat == BC_W'(BEATS - 1));
    assign burst_done = take && last_beat;

    // Burst sequencing: start when idle and running, count accepted beats.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            busy <= 1'b0;
            beat <= '0;
        end else if (!busy) begin
            busy <= run;
            beat <= '0;
        end else if (take) begin
            beat <= last_beat ? '0 : beat + 1'b1;
            busy <= !last_beat;
        end
    end

    // One-beat output register toward the stream sink.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            m_tvalid <= 1'b0;
            m_tdata  <= '0;
            m_tlast  <= 1'b0;
        end else if (take) begin
            m_tvalid <= 1'b1;
            m_tdata  <= mem_rdata;
            m_tlast  <= period_last && last_beat;
        end else if (m_tready) begin
            m_tvalid <= 1'b0;
        end
    end
endmodule

// File: rtl/audio_ring_dma.sv
// Top level of the audio ring playback DMA: register file, position tracker
// and burst fetcher. Assumes one clock domain and a memory that never acks
// without a request.
module audio_ring_dma
    import ard_pkg::*;
#(
    parameter int         ADDR_W     = 64,
    parameter int         DATA_W     = 64,
    parameter int         OFS_W      = 20,
    parameter int         RST_CYCLES = 4,
    parameter logic [3:0] MAX_CH     = 4'd8,
    parameter logic [1:0] XFER_MODE  = 2'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              m_axis_tvalid,
    input  logic              m_axis_tready,
    output logic [DATA_W-1:0] m_axis_tdata,
    output logic              m_axis_tlast,
    output logic              irq
);
    ctrl_t            ctrl;
    logic             srst, flag, period_done, period_last, burst_done;
    logic [63:0]      base;
    logic [15:0]      pbytes;
    logic [3:0]       pcount;
    logic [OFS_W-1:0] pos;

    audio_ring_dma_regs #(
        .OFS_W(OFS_W), .RST_CYCLES(RST_CYCLES), .MAX_CH(MAX_CH), .XFER_MODE(XFER_MODE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .period_done(period_done),
        .pos(pos), .ctrl(ctrl), .srst(srst), .base(base), .pbytes(pbytes),
        .pcount(pcount), .flag(flag), .irq(irq)
    );

    audio_ring_dma_pos #(.OFS_W(OFS_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .srst(srst), .burst_done(burst_done),
        .pbytes(pbytes), .pcount(pcount), .pos(pos), .period_last(period_last),
        .period_done(period_done)
    );

    audio_ring_dma_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .srst(srst), .run(ctrl.run), .base(base),
        .pos(pos), .period_last(period_last), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .m_tvalid(m_axis_tvalid),
        .m_tready(m_axis_tready), .m_tdata(m_axis_tdata), .m_tlast(m_axis_tlast),
        .burst_done(burst_done)
    );
endmodule

// File: rtl/audio_ring_dma_chk.sv
// Assertion checker for audio_ring_dma, attached by bind below.
module audio_ring_dma_chk #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64,
    parameter int OFS_W  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              srst,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              m_tvalid,
    input logic              m_tready,
    input logic [DATA_W-1:0] m_tdata,
    input logic [OFS_W-1:0]  pos,
    input logic [15:0]       pbytes,
    input logic [3:0]        pcount,
    input logic              flag,
    input logic              period_done
);
    logic [19:0] ring;
    assign ring = 20'(pbytes) * 20'(pcount);

    // R11: a stalled beat holds its valid and data.
    a_r11_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready && !srst) |=> (srst || (m_tvalid && $stable(m_tdata))));

    // R10: no memory request while the soft reset runs.
    a_r10_quiet_reset: assert property (@(posedge clk) disable iff (!rst_n)
        srst |-> !mem_req);

    // R5: position stays burst-aligned.
    a_r5_pos_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        pos[5:0] == 6'd0);

    // R5: position stays inside a programmed ring.
    a_r5_pos_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (pcount >= 4'd2 && pbytes >= 16'd192) |-> (20'(pos) < ring));

    // R4: burst address holds until the burst finishes.
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (srst || $stable(mem_addr)));

    // R7: the flag only rises after a period-ending burst.
    a_r7_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(period_done));
endmodule

bind audio_ring_dma audio_ring_dma_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .srst(srst), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .m_tvalid(m_axis_tvalid), .m_tready(m_axis_tready),
    .m_tdata(m_axis_tdata), .pos(pos), .pbytes(pbytes), .pcount(pcount),
    .flag(flag), .period_done(period_done)
);

// File: tb/audio_ring_dma_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: push_ring() queues expected beats, the negedge monitor
// pops and compares every stream transfer.
module audio_ring_dma_tb;
    localparam logic [7:0] A_CORE = 8'h04, A_CTRL = 8'h10, A_STAT = 8'h14,
                           A_PCFG = 8'h1C, A_BLO = 8'h20, A_BHI = 8'h24, A_POS = 8'h28;
    localparam logic [63:0] BASE = 64'h0000_0010_0000_2000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0, reg_rdata;
    logic        mem_req, mem_ack = 1'b0;
    logic [63:0] mem_addr, mem_rdata = 64'h0;
    logic        tvalid, tready = 1'b0, tlast, irq;
    logic [63:0] tdata;

    int   checks = 0, fails = 0, seen = 0;
    bit   stall = 0, hold = 0, beat_clr = 0;
    int   beat_i = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [64:0] q[$];

    audio_ring_dma u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .m_axis_tvalid(tvalid), .m_axis_tready(tready), .m_axis_tdata(tdata),
        .m_axis_tlast(tlast), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic push_ring(input int pb, input int pc, input int start, input int n);
        for (int k = 0; k < n; k++) begin
            int o;
            o = (start + 8 * k) % (pb * pc);
            q.push_back({(((o + 8) % pb) == 0), BASE + 64'(o)});
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    // Memory model beat counter.
    always @(posedge clk) begin
        if (beat_clr) beat_i = 0;
        else if (mem_req && mem_ack) beat_i = (beat_i == 7) ? 0 : beat_i + 1;
    end

    // Sink, memory responder and scoreboard monitor.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tready = hold ? 1'b0 : (stall ? (lfsr[0] | lfsr[3]) : 1'b1);
        #1;
        mem_ack = !hold && mem_req && (stall ? (lfsr[5] | lfsr[9]) : 1'b1);
        mem_rdata = mem_addr + 64'(beat_i) * 64'd8;
        if (tvalid && tready && rst_n) begin
            seen++;
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R4 beat %0d: actual %h expected none", seen, tdata);
            end else begin
                logic [64:0] e;
                e = q.pop_front();
                if ({tlast, tdata} !== e) begin
                    fails++;
                    $display("FAIL R4 and R6 beat %0d: actual %h expected %h",
                             seen, {tlast, tdata}, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        cycles(150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int s;
        cycles(3);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL, v); chk("R1 ctrl", 64'(v), 0);
        rd(A_STAT, v); chk("R1 status", 64'(v), 0);
        rd(A_POS, v);  chk("R1 position", 64'(v), 0);
        rd(A_CORE, v); chk("R1 config word", 64'(v), 64'h0000_C800);
        chk("R1 outputs", {61'b0, irq, mem_req, tvalid}, 0);

        // R2 / R3 field read-back
        wr(A_CTRL, (32'd2 << 19) | (32'd3 << 16) | (32'd1 << 14) | (32'd1 << 13));
        rd(A_CTRL, v); chk("R2 ctrl fields", 64'(v), 64'h0013_6000);
        wr(A_PCFG, (32'd3 << 16) | 32'd192);
        wr(A_BLO, BASE[31:0]);
        wr(A_BHI, BASE[63:32]);
        rd(A_PCFG, v); chk("R3 period cfg", 64'(v), 64'h0003_00C0);
        rd(A_BLO, v);  chk("R3 base low", 64'(v), 64'(BASE[31:0]));
        rd(A_BHI, v);  chk("R3 base high", 64'(v), 64'(BASE[63:32]));

        // R4 R5 R6 stall-free run over several wraps of a 3 x 192 ring
        push_ring(192, 3, 0, 400);
        seen = 0;
        wr(A_CTRL, 32'h0013_6001);
        while (seen < 120) @(posedge clk);
        wr(A_CTRL, 32'h0013_6000);
        cycles(40);
        chk("R9 whole bursts", 64'(seen % 8), 0);
        chk("R9 no request", 64'(mem_req), 0);
        rd(A_POS, v); chk("R9 R5 position", 64'(v), 64'((seen * 8) % 576));
        s = int'(v);
        q.delete();

        // R7 R8 flag and interrupt
        rd(A_STAT, v); chk("R7 flag set", 64'(v[31]), 1);
        chk("R8 irq with enable", 64'(irq), 1);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R7 write 0 keeps flag", 64'(v[31]), 1);
        wr(A_STAT, 32'h8000_0000);
        rd(A_STAT, v); chk("R7 write 1 clears", 64'(v[31]), 0);
        chk("R8 irq low after clear", 64'(irq), 0);

        // R11 stalled run with completion interrupt disabled
        stall = 1;
        push_ring(192, 3, s, 400);
        seen = 0;
        wr(A_CTRL, 32'h0013_4001);
        v = 0;
        while (!v[31]) rd(A_STAT, v);
        chk("R8 irq masked", 64'(irq), 0);
        while (seen < 100) @(posedge clk);
        wr(A_CTRL, 32'h0013_4000);
        cycles(80);
        chk("R9 R11 whole bursts", 64'(seen % 8), 0);
        rd(A_POS, v); chk("R9 R11 position", 64'(v), 64'((s + seen * 8) % 576));
        q.delete();
        wr(A_CTRL, 32'h0013_6000);
        chk("R8 irq on enable", 64'(irq), 1);

        // R10 soft reset in the middle of a burst
        push_ring(192, 3, int'(v), 400);
        wr(A_CTRL, 32'h0013_6001);
        cycles(37);
        hold = 1;
        cycles(3);
        wr(A_CTRL, 32'h0013_6002);
        rd(A_CTRL, v); chk("R10 busy bit", 64'(v[1]), 1);
        cycles(6);
        rd(A_CTRL, v); chk("R10 self clear", 64'(v), 64'h0013_6000);
        rd(A_POS, v);  chk("R10 position", 64'(v), 0);
        rd(A_STAT, v); chk("R10 flag", 64'(v), 0);
        chk("R10 beat dropped", {62'b0, tvalid, irq}, 0);
        q.delete();
        @(negedge clk); beat_clr = 1; @(negedge clk); beat_clr = 0;
        hold = 0;

        // R5 R6 new 2 x 256 ring from the base address, with stalls
        wr(A_PCFG, (32'd2 << 16) | 32'd256);
        push_ring(256, 2, 0, 300);
        seen = 0;
        wr(A_CTRL, 32'h0013_6001);
        while (seen < 150) @(posedge clk);
        wr(A_CTRL, 32'h0013_6000);
        cycles(80);
        rd(A_POS, v); chk("R5 position new ring", 64'(v), 64'((seen * 8) % 512));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule